// File: doc/BRIEF.md
# Pipelined Synchronous Burst-Style SRAM

This block is an on-chip memory that behaves, at its ports, like a pipelined synchronous SRAM with byte-lane writes. The address, write data, the three chip selects and all write controls are registered on the rising edge of the clock. A selected cycle with no lane enabled is a read. Its data passes through an output register and is shown one cycle after the cycle in which the address was taken.

Writes may change any subset of the 9-bit lanes. A lane-write master enable gates the per-lane enables, and a global write strobe overrides both and writes every lane. An asynchronous output enable gates the registered data. A drive flag shows when the data output would be driven rather than floating; floating data reads as zero. The lane count is a parameter: 2 lanes give an 18-bit bus, 4 lanes a 36-bit bus. Burst address generation is not part of this block. An external sequencer supplies each address.

Top module: `piped_sync_ram`

## Requirements
- R1: The block is selected in a cycle only when `sel_n`=0, `sel2`=1 and `sel3_n`=0 at the edge. Any other combination writes nothing, and the drive flag is low one cycle later.
- R2: A selected read with address A taken at edge N shows `mem[A]` on `rdata` with `rdata_valid`=1 from edge N+1 until edge N+2.
- R3: When `gwr_n`=0 in a selected cycle, every lane of the addressed word is written, whatever `bwe_n` and `lane_we_n` hold.
- R4: When `gwr_n`=1 and `bwe_n`=0, lane i (data bits [9i+8:9i]) is written exactly when `lane_we_n[i]`=0. Lanes that are not enabled keep their old contents.
- R5: When `gwr_n`=1 and `bwe_n`=1, the values of `lane_we_n` are ignored. The cycle is a read and the memory is unchanged.
- R6: A deselect or a write taken at edge N drives `rdata_valid` low only after edge N+1, so the output floats two edges after the deselect. A read taken at edge N-1 is still shown between edges N and N+1.
- R7: `oe_n` acts without a clock. While `oe_n`=1, `rdata_valid` is 0 and `rdata` is all zeros. When `oe_n` returns to 0, the registered read data reappears at once.
- R8: A read of address A in the cycle right after a write to A returns the newly written lanes.
- R9: Each of the `LANES` lanes is written on its own. With 4 lanes, enabling one lane at a time changes only that lane's 9 bits.
- R10: While `rst_n`=0, `rdata_valid` is 0 and `rdata` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous inputs are taken on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| addr | input | AW | Word address |
| wdata | input | LANES*9 | Write data, lane i in bits [9i+8:9i] |
| sel_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| gwr_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Lane-write master enable, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*9 | Read data; zero while floating |
| rdata_valid | output | 1 | High while the data output is driven |

## Verification
The bench builds the block with 4 lanes and a depth of 64 words. The wide bus lets single-lane writes on the upper lanes 2 and 3 be told apart from the lower pair. The small depth lets the first and last addresses be swept completely with all lanes written and read back. A reference memory in the bench predicts every output cycle, including cycles that float after deselects and writes. Mid-cycle toggles of the output enable show that it acts without a clock.

// File: rtl/piped_sync_ram.sv
module piped_sync_ram #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  parameter int DEPTH  = 256,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int DW = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             sel_n,
  input  logic             sel2,
  input  logic             sel3_n,
  input  logic             gwr_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] lane_we_n,
  input  logic             oe_n,
  output logic [DW-1:0]    rdata,
  output logic             rdata_valid
);

  logic             cs_in;
  logic [LANES-1:0] lane_in;
  logic             cs_q, wr_q, rd_v_q;
  logic [LANES-1:0] lane_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [DW-1:0]    dout;

  assign cs_in   = !sel_n && sel2 && !sel3_n;
  assign lane_in = !gwr_n ? '1 : (!bwe_n ? ~lane_we_n : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b0;
      wr_q   <= 1'b0;
      lane_q <= '0;
      rd_v_q <= 1'b0;
    end else begin
      cs_q   <= cs_in;
      wr_q   <= cs_in && (|lane_in);
      lane_q <= cs_in ? lane_in : '0;
      rd_v_q <= cs_q && !wr_q;
    end
  end

  always_ff @(posedge clk) begin
    addr_q  <= addr;
    wdata_q <= wdata;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] dout_l;

    always_ff @(posedge clk) begin
      if (wr_q && lane_q[g])
        mem[addr_q] <= wdata_q[g*LANE_W +: LANE_W];
      if (cs_q && !wr_q)
        dout_l <= mem[addr_q];
    end

    assign dout[g*LANE_W +: LANE_W] = dout_l;
  end

  assign rdata_valid = rd_v_q && !oe_n;
  assign rdata       = rdata_valid ? dout : '0;

  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_in && gwr_n && (bwe_n || lane_we_n == '1)) |=> ##1 rd_v_q);

  a_r4_lane_write_floats: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_in && gwr_n && !bwe_n && lane_we_n != '1) |=> ##1 !rd_v_q);

  a_r5_master_off_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_in && gwr_n && bwe_n) |=> ##1 rd_v_q);

  a_r6_two_cycle_float: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_in |=> ##1 !rd_v_q);

endmodule

// File: tb/piped_sync_ram_tb.sv
module piped_sync_ram_tb;
  localparam int LANES = 4, LANE_W = 9, DEPTH = 64, AW = 6, DW = LANES * LANE_W;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n = 1'b0;
  logic [AW-1:0]    addr = '0;
  logic [DW-1:0]    wdata = '0;
  logic             sel_n = 1'b1, sel2 = 1'b1, sel3_n = 1'b0;
  logic             gwr_n = 1'b1, bwe_n = 1'b1;
  logic [LANES-1:0] lane_we_n = '1;
  logic             oe_n = 1'b0;
  logic [DW-1:0]    rdata;
  logic             rdata_valid;

  piped_sync_ram #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .sel_n(sel_n), .sel2(sel2), .sel3_n(sel3_n),
    .gwr_n(gwr_n), .bwe_n(bwe_n), .lane_we_n(lane_we_n),
    .oe_n(oe_n), .rdata(rdata), .rdata_valid(rdata_valid));

  int n_cmp = 0, n_bad = 0, edge_cnt = 0;
  bit done = 1'b0;
  logic mon_last_valid = 1'b0;
  logic [DW-1:0] model [DEPTH];
  int         due_q[$];
  logic [DW:0] exp_q[$];
  string      tag_q[$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input logic s1n, input logic s2, input logic s3n, input logic gwn,
                    input logic bwen, input logic [LANES-1:0] lwn, input logic [AW-1:0] a,
                    input logic [DW-1:0] d, input string tag, input bit probe = 1'b0);
    logic sel;
    logic [LANES-1:0] en;
    @(negedge clk);
    sel_n = s1n; sel2 = s2; sel3_n = s3n; gwr_n = gwn; bwe_n = bwen;
    lane_we_n = lwn; addr = a; wdata = d;
    sel = !s1n && s2 && !s3n;
    en  = !gwn ? '1 : (!bwen ? ~lwn : '0);
    if (sel && en != '0) begin
      for (int i = 0; i < LANES; i++)
        if (en[i]) model[a][i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
      exp_q.push_back({1'b0, {DW{1'b0}}});
    end else if (sel) begin
      exp_q.push_back({1'b1, model[a]});
    end else begin
      exp_q.push_back({1'b0, {DW{1'b0}}});
    end
    due_q.push_back(edge_cnt + 2);
    tag_q.push_back(tag);
    if (probe) begin
      #2 oe_n = 1'b1;
      #1 check(!rdata_valid && rdata == '0, "R7 oe high floats", {27'd0, rdata_valid, rdata}, 64'd0);
      oe_n = 1'b0;
      #1 check(rdata_valid == mon_last_valid, "R7 oe low restores", {63'd0, rdata_valid}, {63'd0, mon_last_valid});
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag, input bit probe = 1'b0);
    op(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, '1, a, '0, tag, probe);
  endtask

  task automatic gw(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    op(1'b0, 1'b1, 1'b0, 1'b0, a[0], a[3:0], a, d, tag);
  endtask

  task automatic bw(input logic [AW-1:0] a, input logic [LANES-1:0] lwn, input logic [DW-1:0] d, input string tag);
    op(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, lwn, a, d, tag);
  endtask

  task automatic idle(input string tag);
    op(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, '1, '0, '0, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      edge_cnt++;
      #5;
      if (due_q.size() > 0 && due_q[0] == edge_cnt) begin
        logic [DW:0] e;
        string t;
        void'(due_q.pop_front());
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e[DW] && !oe_n)
          check(rdata_valid && rdata == e[DW-1:0], t, {27'd0, rdata_valid, rdata}, {27'd0, 1'b1, e[DW-1:0]});
        else
          check(!rdata_valid && rdata == '0, t, {27'd0, rdata_valid, rdata}, 64'd0);
      end
      mon_last_valid = rdata_valid;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 check(!rdata_valid && rdata == '0, "R10 reset", {27'd0, rdata_valid, rdata}, 64'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int a = 0; a < DEPTH; a++)
      gw(AW'(a), {9'(a*7+1), 9'(a*5+3), 9'(a*3+2), 9'(a+11)}, "R3 gw write");
    for (int a = 0; a < DEPTH; a++)
      rd(AW'(a), "R3 all lanes read back");

    bw(6'd5, 4'b1010, 36'h1_2345_6789, "R4 lanes 0,2 write");
    bw(6'd6, 4'b0111, 36'hF_EDCB_A987, "R4 lane 3 write");
    rd(6'd5, "R4 readback");
    rd(6'd6, "R4 readback");

    op(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'b0000, 6'd7, 36'hF_FFFF_FFFF, "R5 master off is read");
    rd(6'd7, "R5 memory unchanged");

    op(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '1, 6'd8, 36'h0_0000_0000, "R1 sel_n high");
    op(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '1, 6'd8, 36'h0_0000_0000, "R1 sel2 low");
    op(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, '1, 6'd8, 36'h0_0000_0000, "R1 sel3_n high");
    rd(6'd8, "R1 no write when deselected");

    gw(6'd9, 36'h5_5AA5_A55A, "R8 write");
    rd(6'd9, "R8 read right after write");
    bw(6'd9, 4'b1101, 36'h0_0003_FE00, "R8 lane write");
    rd(6'd9, "R8 read right after lane write");

    rd(6'd10, "R6 read before deselect");
    idle("R6 deselect floats");
    rd(6'd11, "R6 read between");
    gw(6'd12, 36'h3_3333_3333, "R6 write floats");
    rd(6'd12, "R6 read after write");

    rd(6'd13, "R7 read");
    rd(6'd14, "R7 read");
    rd(6'd15, "R7 read", 1'b1);

    for (int i = 0; i < LANES; i++) begin
      bw(6'd20, ~(4'b0001 << i), 36'hF_FFFF_FFFF, "R9 single lane write");
      rd(6'd20, "R9 single lane readback");
    end

    rd(6'd0, "R2 first address");
    rd(6'd63, "R2 last address");
    repeat (4) idle("R6 drain");
    repeat (4) @(posedge clk);
    #8;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule